// File: doc/BRIEF.md
# Capability Chain Walker

This block traverses a chain of 32-bit capability headers held in a register space. On a start pulse it takes the first header location from a list-head value, reads that header through a read port of fixed latency, and decodes it into three fields: an identifier, a version and a pointer to the following header. Each recognised identifier has its own slot, in which the walker marks the capability as present and stores the header's location and version. The walker then follows the pointer, and repeats until the pointer is zero or the walk has to stop.

The walk stops early in three cases. A header that reads back as all ones stops it at once. An identifier that matches no slot stops it after that header. A hop limit stops it once more headers have been visited than the limit allows, which guards against a corrupt chain that loops back on itself. Each case has its own error flag. A single-cycle done pulse marks the end of every walk. Software, or a boot sequencer, reads the slot outputs once done has fired.

Top module: `cap_chain_walker`

## Requirements
- R1: After reset, busy, done, rd_req, every found bit and all three error flags are 0.
- R2: A start pulse taken while idle raises rd_req in the next cycle, with rd_addr equal to the head_ofs value sampled with start. busy rises in that same cycle.
- R3: Each header is requested with a single-cycle rd_req. rd_data is sampled exactly RD_LAT cycles after that request cycle (default RD_LAT = 2). Every header visited is read exactly once, in chain order.
- R4: Header layout: bits [15:0] hold the next pointer, bits [27:16] the identifier and bits [31:28] the version. The next read address is the value of bits [15:0]. When that value is 0 the walk ends with no error flag set.
- R5: The slots map identifier 0x001 to slot 0 (multi-link), 0x002 to slot 1 (time sync), 0x003 to slot 2 (processing pipe), 0x004 to slot 3 (stream position) and 0x005 to slot 4 (DMA resume). A matching header sets found[k], stores its own address in cap_ofs[16k+15:16k] and its version in cap_ver[4k+3:4k]. If an identifier repeats, the later header's address and version are the ones kept.
- R6: A header equal to 0xFFFFFFFF sets err_bad, records nothing and ends the walk with no further read.
- R7: A header whose identifier matches no slot sets err_unk and ends the walk after that header, whatever its next pointer holds.
- R8: With MAX_HOPS = 10, the walker decodes and records the 11th header of a walk normally, then sets err_hops and ends the walk, even if that header's next pointer is 0. A chain of exactly 10 headers that ends in pointer 0 leaves err_hops clear.
- R9: A start that is taken clears every found bit, every error flag and all slot contents left from the previous walk.
- R10: done is high for exactly one cycle at the end of every walk, whether it ended normally or on an error. busy is low in that cycle.
- R11: A start pulse while busy is high is ignored. The walk in progress keeps its read sequence and results, and no extra done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| head_ofs | input | 16 | Address of the first header |
| rd_req | output | 1 | Header read request, one cycle per header |
| rd_addr | output | 16 | Address of the header being read |
| rd_data | input | 32 | Header data, valid RD_LAT cycles after rd_req |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| found | output | 5 | Per-slot presence flags |
| cap_ofs | output | 80 | Per-slot header address, 16 bits per slot |
| cap_ver | output | 20 | Per-slot header version, 4 bits per slot |
| err_bad | output | 1 | Walk ended on an all-ones header |
| err_unk | output | 1 | Walk ended on an unrecognised identifier |
| err_hops | output | 1 | Walk exceeded the hop limit |

## Verification
The hardest case to reach is the hop limit. A well-formed chain ends long before ten headers, so the bench builds two chains to drive the walker past it. One is a two-header ring whose pointers refer to each other. The other is a straight chain of eleven headers whose last pointer is zero, and this one shows that the limit takes precedence over a normal end. A third chain of exactly ten headers shows that the limit is not reached early. A start pulse injected in the middle of a walk shows that the read sequence does not change and that no extra result appears.

// File: rtl/cap_walk_pkg.sv
package cap_walk_pkg;

   localparam int HDR_W = 32;

   typedef struct packed {
      logic bad;
      logic unk;
      logic hops;
   } walk_err_t;

   function automatic logic hdr_is_void(input logic [HDR_W-1:0] h);
      return &h;
   endfunction

endpackage

// File: rtl/cap_hdr_decode.sv
module cap_hdr_decode
   import cap_walk_pkg::*;
#(
   parameter int NCAP    = 5,
   parameter int NXT_LSB = 0,
   parameter int NXT_W   = 16,
   parameter int ID_LSB  = 16,
   parameter int ID_W    = 12,
   parameter int VER_LSB = 28,
   parameter int VER_W   = 4,
   parameter logic [NCAP*ID_W-1:0] CAP_IDS = '0
) (
   input  logic [HDR_W-1:0] hdr,
   output logic             is_void,
   output logic [NCAP-1:0]  hit,
   output logic             known,
   output logic [NXT_W-1:0] nxt,
   output logic [VER_W-1:0] ver
);

   logic [ID_W-1:0] id;

   assign id      = hdr[ID_LSB +: ID_W];
   assign nxt     = hdr[NXT_LSB +: NXT_W];
   assign ver     = hdr[VER_LSB +: VER_W];
   assign is_void = hdr_is_void(hdr);
   assign known   = |hit;

   for (genvar k = 0; k < NCAP; k++) begin : g_match
      assign hit[k] = (id == CAP_IDS[k*ID_W +: ID_W]);
   end

endmodule

// File: rtl/cap_read_seq.sv
module cap_read_seq #(
   parameter int RD_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic rd_req,
   output logic data_ok
);

   logic [RD_LAT-1:0] lat_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_req <= 1'b0;
      else        rd_req <= launch;
   end

   if (RD_LAT == 1) begin : g_lat_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lat_sr <= '0;
         else        lat_sr <= rd_req;
      end
   end else begin : g_lat_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lat_sr <= '0;
         else        lat_sr <= {lat_sr[RD_LAT-2:0], rd_req};
      end
   end

   assign data_ok = lat_sr[RD_LAT-1];

endmodule

// File: rtl/cap_rec_bank.sv
module cap_rec_bank #(
   parameter int NCAP  = 5,
   parameter int OFS_W = 16,
   parameter int VER_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  wr,
   input  logic [NCAP-1:0]       hit,
   input  logic [OFS_W-1:0]      ofs_in,
   input  logic [VER_W-1:0]      ver_in,
   output logic [NCAP-1:0]       found,
   output logic [NCAP*OFS_W-1:0] ofs_out,
   output logic [NCAP*VER_W-1:0] ver_out
);

   for (genvar k = 0; k < NCAP; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            found[k]                   <= 1'b0;
            ofs_out[k*OFS_W +: OFS_W]  <= '0;
            ver_out[k*VER_W +: VER_W]  <= '0;
         end else if (clr) begin
            found[k]                   <= 1'b0;
            ofs_out[k*OFS_W +: OFS_W]  <= '0;
            ver_out[k*VER_W +: VER_W]  <= '0;
         end else if (wr && hit[k]) begin
            found[k]                   <= 1'b1;
            ofs_out[k*OFS_W +: OFS_W]  <= ofs_in;
            ver_out[k*VER_W +: VER_W]  <= ver_in;
         end
      end
   end

endmodule

// File: rtl/cap_chain_walker.sv
module cap_chain_walker
   import cap_walk_pkg::*;
#(
   parameter int NCAP     = 5,
   parameter int RD_LAT   = 2,
   parameter int MAX_HOPS = 10,
   parameter int NXT_LSB  = 0,
   parameter int NXT_W    = 16,
   parameter int ID_LSB   = 16,
   parameter int ID_W     = 12,
   parameter int VER_LSB  = 28,
   parameter int VER_W    = 4,
   parameter logic [NCAP*ID_W-1:0] CAP_IDS =
      {12'h005, 12'h004, 12'h003, 12'h002, 12'h001},
   localparam int OFS_W = NXT_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [OFS_W-1:0]      head_ofs,
   output logic                  rd_req,
   output logic [OFS_W-1:0]      rd_addr,
   input  logic [HDR_W-1:0]      rd_data,
   output logic                  busy,
   output logic                  done,
   output logic [NCAP-1:0]       found,
   output logic [NCAP*OFS_W-1:0] cap_ofs,
   output logic [NCAP*VER_W-1:0] cap_ver,
   output logic                  err_bad,
   output logic                  err_unk,
   output logic                  err_hops
);

   localparam int HOP_W = $clog2(MAX_HOPS + 2);

   if (RD_LAT < 1) begin : g_bad_lat
      $error("cap_chain_walker: RD_LAT must be at least 1");
   end
   if (NCAP < 1) begin : g_bad_ncap
      $error("cap_chain_walker: NCAP must be at least 1");
   end
   if (MAX_HOPS < 1) begin : g_bad_hops
      $error("cap_chain_walker: MAX_HOPS must be at least 1");
   end
   if (NXT_LSB + NXT_W > HDR_W || ID_LSB + ID_W > HDR_W ||
       VER_LSB + VER_W > HDR_W) begin : g_bad_field
      $error("cap_chain_walker: header field exceeds header width");
   end

   logic             busy_q, done_q;
   logic [OFS_W-1:0] cur_q;
   logic [HOP_W-1:0] visits_q, visits_nxt;
   walk_err_t        err_q;

   logic             data_ok, accept, eval, finish, launch, over;
   logic             is_void, known;
   logic [NCAP-1:0]  hit;
   logic [NXT_W-1:0] nxt;
   logic [VER_W-1:0] ver;
   logic [OFS_W-1:0] nxt_eff;

   cap_hdr_decode #(
      .NCAP(NCAP), .NXT_LSB(NXT_LSB), .NXT_W(NXT_W), .ID_LSB(ID_LSB),
      .ID_W(ID_W), .VER_LSB(VER_LSB), .VER_W(VER_W), .CAP_IDS(CAP_IDS)
   ) u_dec (
      .hdr(rd_data), .is_void(is_void), .hit(hit), .known(known),
      .nxt(nxt), .ver(ver)
   );

   cap_read_seq #(.RD_LAT(RD_LAT)) u_seq (
      .clk(clk), .rst_n(rst_n), .launch(launch),
      .rd_req(rd_req), .data_ok(data_ok)
   );

   cap_rec_bank #(.NCAP(NCAP), .OFS_W(OFS_W), .VER_W(VER_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(accept), .wr(eval && !is_void),
      .hit(hit), .ofs_in(cur_q), .ver_in(ver),
      .found(found), .ofs_out(cap_ofs), .ver_out(cap_ver)
   );

   assign accept     = start && !busy_q;
   assign eval       = data_ok && busy_q;
   assign visits_nxt = visits_q + HOP_W'(1);
   assign over       = (visits_nxt > HOP_W'(MAX_HOPS));
   assign nxt_eff    = known ? nxt : '0;
   assign finish     = eval && (is_void || over || (nxt_eff == '0));
   assign launch     = accept || (eval && !finish);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         cur_q    <= '0;
         visits_q <= '0;
         err_q    <= '0;
      end else begin
         done_q <= finish;
         if (accept) begin
            busy_q   <= 1'b1;
            cur_q    <= head_ofs;
            visits_q <= '0;
            err_q    <= '0;
         end else if (eval) begin
            visits_q <= visits_nxt;
            if (is_void) begin
               err_q.bad <= 1'b1;
            end else begin
               if (!known) err_q.unk  <= 1'b1;
               if (over)   err_q.hops <= 1'b1;
            end
            if (finish) busy_q <= 1'b0;
            else        cur_q  <= nxt_eff;
         end
      end
   end

   assign rd_addr  = cur_q;
   assign busy     = busy_q;
   assign done     = done_q;
   assign err_bad  = err_q.bad;
   assign err_unk  = err_q.unk;
   assign err_hops = err_q.hops;

endmodule

// File: rtl/cap_chain_walker_chk.sv
module cap_chain_walker_chk #(
   parameter int NCAP = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic            rd_req,
   input logic [NCAP-1:0] found,
   input logic            err_bad,
   input logic            err_unk,
   input logic            err_hops
);

   a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_req);

   a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (rd_req && busy));

   a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   a_r6_bad_ends: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_bad) |-> done);

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (found == '0 && !err_bad && !err_unk && !err_hops));

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(found));

endmodule

bind cap_chain_walker cap_chain_walker_chk #(.NCAP(NCAP)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .rd_req(rd_req), .found(found), .err_bad(err_bad), .err_unk(err_unk),
   .err_hops(err_hops)
);

// File: tb/cap_chain_walker_bench.sv
module cap_chain_walker_bench;

   localparam int NCAP = 5;
   localparam int LAT  = 2;
   localparam int OW   = 16;
   localparam int VW   = 4;

   typedef struct {
      logic [NCAP-1:0]    found;
      logic [NCAP*OW-1:0] ofs;
      logic [NCAP*VW-1:0] ver;
      logic               bad;
      logic               unk;
      logic               hops;
   } exp_t;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic [OW-1:0]        head_ofs = '0;
   logic                 rd_req;
   logic [OW-1:0]        rd_addr;
   logic [31:0]          rd_data;
   logic                 busy, done, err_bad, err_unk, err_hops;
   logic [NCAP-1:0]      found;
   logic [NCAP*OW-1:0]   cap_ofs;
   logic [NCAP*VW-1:0]   cap_ver;

   logic [31:0]          mem [0:255];
   logic [OW-1:0]        pa [LAT];
   logic                 pv [LAT];

   exp_t                 q_exp [$];
   logic [OW-1:0]        q_addr [$];
   int                   n_chk = 0;
   int                   n_bad = 0;
   int                   done_cnt = 0;
   logic                 done_d = 1'b0;

   always #5 clk = ~clk;

   cap_chain_walker #(.RD_LAT(LAT)) u_cap_chain_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .head_ofs(head_ofs),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .done(done), .found(found), .cap_ofs(cap_ofs),
      .cap_ver(cap_ver), .err_bad(err_bad), .err_unk(err_unk),
      .err_hops(err_hops)
   );

   // register-space model with fixed read latency; off-cycle data is a trap value
   always @(posedge clk) begin
      pv[0] <= rd_req;
      pa[0] <= rd_addr;
      for (int i = 1; i < LAT; i++) begin
         pv[i] <= pv[i-1];
         pa[i] <= pa[i-1];
      end
   end
   assign rd_data = pv[LAT-1] ? mem[pa[LAT-1][7:0]] : 32'h5A5A_0000;

   function automatic logic [31:0] hdr(input int v, input int id, input int nx);
      return {v[3:0], id[11:0], nx[15:0]};
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [79:0] act, input logic [79:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
      end
   endtask

   // expected result of a walk, derived from the requirement text
   task automatic model_walk(input logic [OW-1:0] head);
      exp_t e;
      logic [OW-1:0] a;
      logic [31:0] h;
      int visits;
      int id;
      logic [OW-1:0] nx;
      e.found = '0; e.ofs = '0; e.ver = '0;
      e.bad = 1'b0; e.unk = 1'b0; e.hops = 1'b0;
      a = head;
      visits = 0;
      forever begin
         q_addr.push_back(a);
         h = mem[a[7:0]];
         if (h == 32'hFFFF_FFFF) begin e.bad = 1'b1; break; end
         visits++;
         id = int'(h[27:16]);
         if (id >= 1 && id <= NCAP) begin
            e.found[id-1] = 1'b1;
            e.ofs[(id-1)*OW +: OW] = a;
            e.ver[(id-1)*VW +: VW] = h[31:28];
            nx = h[15:0];
         end else begin
            e.unk = 1'b1;
            nx = '0;
         end
         if (visits > 10) begin e.hops = 1'b1; break; end
         if (nx == '0) break;
         a = nx;
      end
      q_exp.push_back(e);
   endtask

   // driver: pushes expectations, then launches the walk (optional intruding start)
   task automatic run_walk(input logic [OW-1:0] head, input bit intrude,
                           input logic [OW-1:0] head2);
      int n0;
      model_walk(head);
      n0 = done_cnt;
      @(negedge clk);
      start = 1'b1; head_ofs = head;
      @(negedge clk);
      start = 1'b0;
      if (intrude) begin
         // R11: this start arrives mid-walk and must be ignored
         repeat (3) @(negedge clk);
         start = 1'b1; head_ofs = head2;
         @(negedge clk);
         start = 1'b0;
      end
      while (done_cnt == n0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor: checks read order and completed walks against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_req) begin
            if (q_addr.size() == 0) begin
               chk(1'b0, "R3 R11 unexpected read", 80'(rd_addr), 80'h0);
            end else begin
               logic [OW-1:0] ea;
               ea = q_addr.pop_front();
               chk(rd_addr == ea, "R2 R4 R11 read address", 80'(rd_addr), 80'(ea));
            end
         end
         chk(!(done && done_d), "R10 done width", 80'(done_d), 80'h0);
         if (done) begin
            done_cnt++;
            chk(!busy, "R10 busy at done", 80'(busy), 80'h0);
            if (q_exp.size() == 0) begin
               chk(1'b0, "R10 R11 extra done", 80'h1, 80'h0);
            end else begin
               exp_t e;
               e = q_exp.pop_front();
               chk(found == e.found, "R5 R9 found", 80'(found), 80'(e.found));
               chk(cap_ofs == e.ofs, "R5 R9 offsets", cap_ofs, e.ofs);
               chk(cap_ver == e.ver, "R5 version", 80'(cap_ver), 80'(e.ver));
               chk(err_bad == e.bad, "R6 err_bad", 80'(err_bad), 80'(e.bad));
               chk(err_unk == e.unk, "R7 err_unk", 80'(err_unk), 80'(e.unk));
               chk(err_hops == e.hops, "R8 err_hops", 80'(err_hops), 80'(e.hops));
               chk(q_addr.size() == 0, "R3 missing reads", 80'(q_addr.size()), 80'h0);
               q_addr.delete();
            end
         end
         done_d <= done;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      // normal three-header chain
      mem[8'h10] = hdr(3, 1, 16'h20);
      mem[8'h20] = hdr(1, 3, 16'h30);
      mem[8'h30] = hdr(2, 5, 0);
      // all five identifiers, slot 1 repeated
      mem[8'h80] = hdr(4, 4, 16'h84);
      mem[8'h84] = hdr(6, 2, 16'h88);
      mem[8'h88] = hdr(1, 1, 16'h8C);
      mem[8'h8C] = hdr(2, 3, 16'h90);
      mem[8'h90] = hdr(7, 2, 16'h94);
      mem[8'h94] = hdr(5, 5, 0);
      // all-ones header
      mem[8'h40] = hdr(1, 1, 16'h44);
      mem[8'h44] = 32'hFFFF_FFFF;
      // unknown identifier with a live pointer
      mem[8'h50] = hdr(2, 2, 16'h54);
      mem[8'h54] = hdr(1, 12'h0F3, 16'h58);
      mem[8'h58] = hdr(3, 1, 0);
      // exactly ten headers
      for (int i = 0; i < 10; i++)
         mem[8'hA0 + 4*i] = hdr(i, (i % 5) + 1, (i == 9) ? 0 : 16'hA4 + 4*i);
      // two-header ring
      mem[8'h60] = hdr(1, 1, 16'h64);
      mem[8'h64] = hdr(2, 2, 16'h60);
      // eleven headers, last pointer zero
      for (int i = 0; i < 11; i++)
         mem[8'hD0 + 4*i] = hdr(i + 2, (i % 5) + 1, (i == 10) ? 0 : 16'hD4 + 4*i);
      // single header at address 0
      mem[8'h00] = hdr(9, 4, 0);

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !rd_req, "R1 control idle",
          80'({busy, done, rd_req}), 80'h0);
      chk(found == '0 && !err_bad && !err_unk && !err_hops, "R1 results clear",
          80'({found, err_bad, err_unk, err_hops}), 80'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_walk(16'h10, 1'b0, 16'h0);   // R4 normal end
      run_walk(16'h80, 1'b0, 16'h0);   // R5 all slots, repeat keeps later
      run_walk(16'h40, 1'b0, 16'h0);   // R6
      run_walk(16'h50, 1'b0, 16'h0);   // R7
      run_walk(16'hA0, 1'b0, 16'h0);   // R8 boundary, no error
      run_walk(16'h60, 1'b0, 16'h0);   // R8 ring
      run_walk(16'hD0, 1'b0, 16'h0);   // R8 eleventh header
      run_walk(16'h10, 1'b1, 16'h40);  // R9 clear after errors, R11 intrusion
      run_walk(16'h00, 1'b0, 16'h0);   // single header at address 0

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule